// File: doc/BRIEF.md
# Direct-Mapped Branch Target Buffer

This block is a direct-mapped table of branch targets for a fetch unit that several hardware threads share. In the same cycle as a request, a lookup port returns a hit flag and the stored target address for an instruction address and a thread identifier. A second query port returns only the hit flag for another address and thread. When a branch resolves, the update port writes its address, target and thread identifier into one entry.

Each entry holds a valid bit, an address tag, the identifier of the thread that wrote it, and a target. The entry index comes from the address bits just above the instruction alignment bits. The tag comes from the bits above the index. A synchronous clear input invalidates the whole table. The asynchronous reset leaves every entry invalid after power-up.

Entry count, tag width, address width, thread identifier width and alignment shift are all parameters. Elaboration stops if the entry count is not a power of two, or if the index and tag fields do not fit in the address.

Top module: `btb_direct`

## Requirements
- R1: After rst_ni is released, and before any update, every lookup and every query misses.
- R2: The entry index is address bits [SHIFT +: log2(ENTRIES)]. The tag is the TAG_W bits directly above the index. Address bits below SHIFT, and bits above the tag field, do not affect which entry is used or whether it hits.
- R3: A lookup hits only when the indexed entry is valid, its stored tag equals the request tag, and its stored thread identifier equals lk_tid_i.
- R4: When hit_o is 0, target_o is all zeros. When hit_o is 1, target_o is the stored target.
- R5: An update overwrites the indexed entry whatever it held before. It sets valid, tag, thread identifier and target, so an older entry with a different tag or thread is evicted.
- R6: Lookups are combinational. An update becomes visible from the cycle after its clock edge. A lookup in the same cycle as an update to the same entry sees the old contents.
- R7: clear_i invalidates all entries at the clock edge and takes priority over an update in the same cycle.
- R8: chk_hit_o applies the hit condition of R3 to chk_addr_i and chk_tid_i, independently of the lookup port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, invalidates all entries |
| clear_i | input | 1 | Synchronous clear of every valid bit |
| lk_addr_i | input | ADDR_W | Lookup instruction address |
| lk_tid_i | input | TID_W | Lookup thread identifier |
| hit_o | output | 1 | Lookup hit |
| target_o | output | ADDR_W | Predicted target, zero on miss |
| chk_addr_i | input | ADDR_W | Query instruction address |
| chk_tid_i | input | TID_W | Query thread identifier |
| chk_hit_o | output | 1 | Query hit |
| upd_en_i | input | 1 | Write one entry |
| upd_addr_i | input | ADDR_W | Resolved branch address |
| upd_tid_i | input | TID_W | Resolved branch thread identifier |
| upd_target_i | input | ADDR_W | Resolved branch target |

## Verification
A wrong valid bit, tag or thread identifier in an entry shows up the moment any port reads that index. It appears as a false hit, a miss where a hit was due, or a target that is nonzero on a miss. The bench keeps its own shadow table and compares both ports on every cycle. A bad write is therefore seen on the first cycle after the write edge. Lookups placed in the same cycle as a write would expose a bypass that should not exist. A clear that is lost or delayed would leave a stale hit one cycle after clear_i.

// File: rtl/btb_pkg.sv
package btb_pkg;

  function automatic bit is_pow2(input int unsigned n);
    return (n != 0) && ((n & (n - 1)) == 0);
  endfunction

endpackage

// File: rtl/btb_addr_split.sv
module btb_addr_split #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned TAG_W  = 8,
  parameter int unsigned SHIFT  = 2
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic [TAG_W-1:0]  tag_o
);
  localparam int unsigned TAG_LSB = SHIFT + IDX_W;

  logic [ADDR_W-1:0] idx_sh, tag_sh;

  always_comb begin
    idx_sh = addr_i >> SHIFT;
    tag_sh = addr_i >> TAG_LSB;
    idx_o  = idx_sh[IDX_W-1:0];
    tag_o  = tag_sh[TAG_W-1:0];
  end
endmodule

// File: rtl/btb_match.sv
module btb_match #(
  parameter int unsigned TAG_W = 8,
  parameter int unsigned TID_W = 2
) (
  input  logic             ent_valid_i,
  input  logic [TAG_W-1:0] ent_tag_i,
  input  logic [TID_W-1:0] ent_tid_i,
  input  logic [TAG_W-1:0] req_tag_i,
  input  logic [TID_W-1:0] req_tid_i,
  output logic             hit_o
);
  assign hit_o = ent_valid_i && (ent_tag_i == req_tag_i) && (ent_tid_i == req_tid_i);
endmodule

// File: rtl/btb_store.sv
module btb_store #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned IDX_W   = 4,
  parameter int unsigned TAG_W   = 8,
  parameter int unsigned TID_W   = 2,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [TAG_W-1:0]  wtag_i,
  input  logic [TID_W-1:0]  wtid_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_a_i,
  output logic              ra_valid_o,
  output logic [TAG_W-1:0]  ra_tag_o,
  output logic [TID_W-1:0]  ra_tid_o,
  output logic [DATA_W-1:0] ra_data_o,
  input  logic [IDX_W-1:0]  ridx_b_i,
  output logic              rb_valid_o,
  output logic [TAG_W-1:0]  rb_tag_o,
  output logic [TID_W-1:0]  rb_tid_o
);
  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [TID_W-1:0]   tid_q  [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    logic sel;
    assign sel = we_i && (widx_i == IDX_W'(e));

    // clear wins over a write in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      valid_q[e] <= 1'b0;
      else if (clear_i) valid_q[e] <= 1'b0;
      else if (sel)     valid_q[e] <= 1'b1;
    end

    // payload needs no reset: guarded by valid
    always_ff @(posedge clk_i) begin
      if (sel) begin
        tag_q[e]  <= wtag_i;
        tid_q[e]  <= wtid_i;
        data_q[e] <= wdata_i;
      end
    end
  end

  always_comb begin
    ra_valid_o = valid_q[ridx_a_i];
    ra_tag_o   = tag_q[ridx_a_i];
    ra_tid_o   = tid_q[ridx_a_i];
    ra_data_o  = data_q[ridx_a_i];
    rb_valid_o = valid_q[ridx_b_i];
    rb_tag_o   = tag_q[ridx_b_i];
    rb_tid_o   = tid_q[ridx_b_i];
  end
endmodule

// File: rtl/btb_direct.sv
module btb_direct #(
  parameter int unsigned ENTRIES = 16,
  parameter int unsigned TAG_W   = 8,
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned TID_W   = 2,
  parameter int unsigned SHIFT   = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic [ADDR_W-1:0] lk_addr_i,
  input  logic [TID_W-1:0]  lk_tid_i,
  output logic              hit_o,
  output logic [ADDR_W-1:0] target_o,
  input  logic [ADDR_W-1:0] chk_addr_i,
  input  logic [TID_W-1:0]  chk_tid_i,
  output logic              chk_hit_o,
  input  logic              upd_en_i,
  input  logic [ADDR_W-1:0] upd_addr_i,
  input  logic [TID_W-1:0]  upd_tid_i,
  input  logic [ADDR_W-1:0] upd_target_i
);
  localparam int unsigned IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  if (!btb_pkg::is_pow2(ENTRIES) || ENTRIES < 2) begin : g_bad_entries
    $error("btb_direct: ENTRIES must be a power of two, at least 2");
  end
  if (SHIFT + IDX_W + TAG_W > ADDR_W) begin : g_bad_fields
    $error("btb_direct: index and tag fields exceed ADDR_W");
  end

  logic [IDX_W-1:0] lk_idx, chk_idx, upd_idx;
  logic [TAG_W-1:0] lk_tag, chk_tag, upd_tag;

  btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .SHIFT(SHIFT)) i_split_lk (
    .addr_i(lk_addr_i), .idx_o(lk_idx), .tag_o(lk_tag));
  btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .SHIFT(SHIFT)) i_split_chk (
    .addr_i(chk_addr_i), .idx_o(chk_idx), .tag_o(chk_tag));
  btb_addr_split #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .TAG_W(TAG_W), .SHIFT(SHIFT)) i_split_upd (
    .addr_i(upd_addr_i), .idx_o(upd_idx), .tag_o(upd_tag));

  logic              a_valid, b_valid;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [TID_W-1:0]  a_tid, b_tid;
  logic [ADDR_W-1:0] a_data;

  btb_store #(
    .ENTRIES(ENTRIES), .IDX_W(IDX_W), .TAG_W(TAG_W), .TID_W(TID_W), .DATA_W(ADDR_W)
  ) i_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clear_i   (clear_i),
    .we_i      (upd_en_i),
    .widx_i    (upd_idx),
    .wtag_i    (upd_tag),
    .wtid_i    (upd_tid_i),
    .wdata_i   (upd_target_i),
    .ridx_a_i  (lk_idx),
    .ra_valid_o(a_valid),
    .ra_tag_o  (a_tag),
    .ra_tid_o  (a_tid),
    .ra_data_o (a_data),
    .ridx_b_i  (chk_idx),
    .rb_valid_o(b_valid),
    .rb_tag_o  (b_tag),
    .rb_tid_o  (b_tid)
  );

  logic lk_hit;

  btb_match #(.TAG_W(TAG_W), .TID_W(TID_W)) i_match_lk (
    .ent_valid_i(a_valid), .ent_tag_i(a_tag), .ent_tid_i(a_tid),
    .req_tag_i(lk_tag), .req_tid_i(lk_tid_i), .hit_o(lk_hit));
  btb_match #(.TAG_W(TAG_W), .TID_W(TID_W)) i_match_chk (
    .ent_valid_i(b_valid), .ent_tag_i(b_tag), .ent_tid_i(b_tid),
    .req_tag_i(chk_tag), .req_tid_i(chk_tid_i), .hit_o(chk_hit_o));

  assign hit_o    = lk_hit;
  assign target_o = lk_hit ? a_data : '0;
endmodule

// File: rtl/btb_direct_checker.sv
module btb_direct_checker #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned TID_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clear_i,
  input logic [ADDR_W-1:0] lk_addr_i,
  input logic [TID_W-1:0]  lk_tid_i,
  input logic              hit_o,
  input logic [ADDR_W-1:0] target_o,
  input logic [ADDR_W-1:0] chk_addr_i,
  input logic [TID_W-1:0]  chk_tid_i,
  input logic              chk_hit_o,
  input logic              upd_en_i,
  input logic [ADDR_W-1:0] upd_addr_i,
  input logic [TID_W-1:0]  upd_tid_i,
  input logic [ADDR_W-1:0] upd_target_i
);
  logic seen_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) seen_q <= 1'b0;
    else         seen_q <= 1'b1;
  end

  a_r1_empty_after_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seen_q |-> !hit_o && !chk_hit_o);

  a_r4_miss_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> target_o == '0);

  a_r6_write_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(upd_en_i && !clear_i) && lk_addr_i == $past(upd_addr_i)
      && lk_tid_i == $past(upd_tid_i)
    |-> hit_o && target_o == $past(upd_target_i));

  a_r3_tid_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(upd_en_i && !clear_i) && lk_addr_i == $past(upd_addr_i)
      && lk_tid_i != $past(upd_tid_i)
    |-> !hit_o);

  a_r7_clear_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seen_q && $past(clear_i) |-> !hit_o && !chk_hit_o);

  a_r8_ports_agree: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_addr_i == lk_addr_i && chk_tid_i == lk_tid_i |-> chk_hit_o == hit_o);
endmodule

bind btb_direct btb_direct_checker #(.ADDR_W(ADDR_W), .TID_W(TID_W)) i_btb_direct_checker (.*);

// File: tb/test_btb_direct.sv
module test_btb_direct;
  localparam int unsigned ENTRIES = 16;
  localparam int unsigned TAG_W   = 8;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned TID_W   = 2;
  localparam int unsigned SHIFT   = 2;
  localparam int unsigned IDX_W   = $clog2(ENTRIES);
  localparam time CLK_PERIOD = 10;

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              clear_i = 1'b0;
  logic [ADDR_W-1:0] lk_addr_i = '0, chk_addr_i = '0, upd_addr_i = '0, upd_target_i = '0;
  logic [TID_W-1:0]  lk_tid_i = '0, chk_tid_i = '0, upd_tid_i = '0;
  logic              upd_en_i = 1'b0;
  logic              hit_o, chk_hit_o;
  logic [ADDR_W-1:0] target_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  btb_direct #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .ADDR_W(ADDR_W), .TID_W(TID_W), .SHIFT(SHIFT))
  i_btb_direct (
    .clk_i(clk), .rst_ni(rst_ni), .clear_i(clear_i),
    .lk_addr_i(lk_addr_i), .lk_tid_i(lk_tid_i), .hit_o(hit_o), .target_o(target_o),
    .chk_addr_i(chk_addr_i), .chk_tid_i(chk_tid_i), .chk_hit_o(chk_hit_o),
    .upd_en_i(upd_en_i), .upd_addr_i(upd_addr_i), .upd_tid_i(upd_tid_i),
    .upd_target_i(upd_target_i));

  // shadow table
  bit                m_v   [ENTRIES];
  logic [TAG_W-1:0]  m_tag [ENTRIES];
  logic [TID_W-1:0]  m_tid [ENTRIES];
  logic [ADDR_W-1:0] m_tgt [ENTRIES];

  function automatic int unsigned f_idx(input logic [ADDR_W-1:0] a);
    return (a >> SHIFT) % ENTRIES;
  endfunction
  function automatic logic [TAG_W-1:0] f_tag(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] s;
    s = a >> (SHIFT + IDX_W);
    return s[TAG_W-1:0];
  endfunction
  function automatic bit f_hit(input logic [ADDR_W-1:0] a, input logic [TID_W-1:0] t);
    int unsigned i;
    i = f_idx(a);
    return m_v[i] && m_tag[i] == f_tag(a) && m_tid[i] == t;
  endfunction
  function automatic logic [ADDR_W-1:0] mk(input int unsigned tag, input int unsigned idx,
                                           input int unsigned low);
    return ADDR_W'((tag << (SHIFT + IDX_W)) | (idx << SHIFT) | low);
  endfunction

  task automatic check(input bit ok, input string req, input logic [ADDR_W-1:0] act,
                       input logic [ADDR_W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // one cycle: drive, compare both ports with pre-edge shadow, then clock shadow
  task automatic step(input bit upd, input logic [ADDR_W-1:0] ua, input logic [ADDR_W-1:0] ut,
                      input logic [TID_W-1:0] utid, input bit clr,
                      input logic [ADDR_W-1:0] la, input logic [TID_W-1:0] lt,
                      input logic [ADDR_W-1:0] ca, input logic [TID_W-1:0] ct,
                      input string req);
    bit eh, ec;
    logic [ADDR_W-1:0] et;
    @(negedge clk);
    upd_en_i = upd; upd_addr_i = ua; upd_target_i = ut; upd_tid_i = utid;
    clear_i = clr; lk_addr_i = la; lk_tid_i = lt; chk_addr_i = ca; chk_tid_i = ct;
    #1;
    eh = f_hit(la, lt);
    ec = f_hit(ca, ct);
    et = eh ? m_tgt[f_idx(la)] : '0;
    check(hit_o == eh, {req, " hit"}, ADDR_W'(hit_o), ADDR_W'(eh));
    check(target_o == et, {req, " target"}, target_o, et);
    check(chk_hit_o == ec, {req, " chk"}, ADDR_W'(chk_hit_o), ADDR_W'(ec));
    @(posedge clk);
    if (clr) begin
      for (int i = 0; i < ENTRIES; i++) m_v[i] = 0;
    end else if (upd) begin
      m_v[f_idx(ua)] = 1; m_tag[f_idx(ua)] = f_tag(ua);
      m_tid[f_idx(ua)] = utid; m_tgt[f_idx(ua)] = ut;
    end
  endtask

  task automatic look(input logic [ADDR_W-1:0] la, input logic [TID_W-1:0] lt, input string req);
    step(0, '0, '0, '0, 0, la, lt, la, lt, req);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    finish_run();
  end

  initial begin
    logic [ADDR_W-1:0] a, b;
    for (int i = 0; i < ENTRIES; i++) begin
      m_v[i] = 0; m_tag[i] = '0; m_tid[i] = '0; m_tgt[i] = '0;
    end
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: empty after power-up, every index
    for (int i = 0; i < ENTRIES; i++) begin
      @(negedge clk); lk_addr_i = mk(i, i, 0); lk_tid_i = '0;
      chk_addr_i = mk(0, i, 1); chk_tid_i = 1; #1;
      check(!hit_o && target_o == '0, "R1 lookup empty", target_o, '0);
      check(!chk_hit_o, "R1 query empty", ADDR_W'(chk_hit_o), '0);
    end

    a = mk(8'h11, 3, 0);
    // R6: same-cycle lookup sees old (invalid) entry
    step(1, a, 32'h1000_0040, 1, 0, a, 1, a, 1, "R6 same cycle");
    look(a, 1, "R6 visible next");
    check(hit_o && target_o == 32'h1000_0040, "R6 hit after write", target_o, 32'h1000_0040);
    // R2: alignment bits and bits above tag ignored
    look(a | 32'h3, 1, "R2 low bits");
    check(hit_o, "R2 low bits hit", ADDR_W'(hit_o), 1);
    look(a | (32'h1 << 20), 1, "R2 high bits");
    check(hit_o, "R2 high bits hit", ADDR_W'(hit_o), 1);
    // R3/R4: tid mismatch and tag mismatch miss with zero target
    look(a, 2, "R3 tid mismatch");
    check(!hit_o && target_o == '0, "R4 zero on tid miss", target_o, '0);
    look(mk(8'h12, 3, 0), 1, "R3 tag mismatch");
    check(!hit_o, "R3 tag miss", ADDR_W'(hit_o), 0);
    // R5: overwrite with a different tag and thread evicts
    b = mk(8'h22, 3, 0);
    step(1, b, 32'h2000_0000, 0, 0, a, 1, b, 0, "R5 overwrite");
    look(a, 1, "R5 old evicted");
    check(!hit_o, "R5 old gone", ADDR_W'(hit_o), 0);
    look(b, 0, "R5 new present");
    check(hit_o && target_o == 32'h2000_0000, "R5 new hit", target_o, 32'h2000_0000);
    // R8: query port on a different address than lookup
    step(0, '0, '0, '0, 0, a, 1, b, 0, "R8 split query");
    check(chk_hit_o && !hit_o, "R8 independent", ADDR_W'({chk_hit_o, hit_o}), 2);
    // R7: clear beats a simultaneous update
    step(1, mk(8'h33, 5, 0), 32'hABCD_0000, 2, 1, b, 0, b, 0, "R7 clear+update");
    look(mk(8'h33, 5, 0), 2, "R7 update dropped");
    check(!hit_o, "R7 no hit", ADDR_W'(hit_o), 0);
    look(b, 0, "R7 cleared");
    check(!hit_o, "R7 old cleared", ADDR_W'(hit_o), 0);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      logic [ADDR_W-1:0] ua, la, ca;
      ua = mk($urandom % 4, $urandom % ENTRIES, $urandom % 4) | (ADDR_W'($urandom) << 16);
      la = ($urandom % 2) ? ua : mk($urandom % 4, $urandom % ENTRIES, $urandom % 4);
      ca = mk($urandom % 4, $urandom % ENTRIES, 0);
      step($urandom % 2, ua, ADDR_W'($urandom), TID_W'($urandom % 3), ($urandom % 64) == 0,
           la, TID_W'($urandom % 3), ca, TID_W'($urandom % 3), "R3 R4 R5 R6 R8 random");
    end

    finish_run();
  end
endmodule